// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block sits in the feedback path of an integer-N frequency synthesizer. It runs on the oscillator clock, which has already been halved, and divides it by a programmable ratio of the form 10·P + S. It emits a single-clock pulse to the phase comparator at the end of every division cycle. The ratio comes from a dual-modulus 10/11 prescaler and two down-counters. The prescaler is made from a divide-by-3/4 core that runs three core periods per output frame. The program counter counts P prescaler frames per division cycle. The swallow counter holds the modulus high for the first S of those frames.

Software-free channel selection is done with three inputs: a request strobe, a reference-mode bit and a channel index. With the coarse mode (20 MHz reference, `mode`=0), P is 25 and channel indices 0 to 7 give S = 9 to 16, so the ratios run from 259 to 266. With the fine mode (5 MHz reference, `mode`=1), P is 114 and channel indices 0 to 12 give S = 9 to 21, so the ratios run from 1149 to 1161. An out-of-range index is refused and the running ratio stays in force. An accepted ratio waits until the current division cycle has finished.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rst_n` is low and on the first clock after it, `fb_pulse` and `req_err` are 0 and `mod_ctl` is 1. The ratio after reset is 259 (P=25, S=9), so consecutive pulses are 259 clocks apart.
- R2: With `mode`=0 and `chan` in 0..7, an accepted request sets the pulse spacing to 250 + 9 + `chan` clocks.
- R3: With `mode`=1 and `chan` in 0..12, an accepted request sets the pulse spacing to 1140 + 9 + `chan` clocks.
- R4: A request with `mode`=0 and `chan` ≥ 8, or with `mode`=1 and `chan` ≥ 13, drives `req_err` to 1 on the clock after the request, and the pulse spacing stays at its previous value.
- R5: A legal request drives `req_err` to 0 on the clock after it. Without a request, `req_err` keeps its value.
- R6: A request changes nothing in the division cycle during which it arrives. The new ratio applies from the next pulse onward. If several requests arrive within one cycle, the last legal one wins.
- R7: `fb_pulse` is high for exactly one clock per division cycle.
- R8: `mod_ctl` is high for exactly 11·S clocks in each division cycle and low for the rest. It goes high on the clock after `fb_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Halved oscillator clock; every register runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-clock strobe that submits `mode` and `chan` |
| mode | input | 1 | Reference mode: 0 = 20 MHz steps (P=25), 1 = 5 MHz steps (P=114) |
| chan | input | 4 | Channel index within the selected mode |
| fb_pulse | output | 1 | One-clock pulse at the end of each division cycle |
| mod_ctl | output | 1 | Modulus control as seen by the prescaler (1 = divide by 11) |
| req_err | output | 1 | Set when the last request was out of range |

## Verification
The error flag settles one clock after the request strobe, so the bench reads it on the falling edge that follows the strobe. The pulse spacing is the division ratio itself. Both intervals are counted from one falling edge that sees `fb_pulse` to the next such edge. A request is always issued on the falling edge where a pulse is seen. The interval that follows must therefore still show the old ratio, and only the interval after it shows the new one. The bench counts clocks with `mod_ctl` high over the same window, so the swallow count is checked in the same cycle as the ratio it belongs to.

// File: rtl/div_pkg.sv
// Package div_pkg
// Default constants shared by the feedback divider and its checker.
// Assumes a 10/11 prescaler and that both modes start their swallow range at 9.
package div_pkg;
    localparam int PRE_N   = 10;   // low prescaler modulus
    localparam int P_LO    = 25;   // program count, 20 MHz mode
    localparam int P_HI    = 114;  // program count, 5 MHz mode
    localparam int S_BASE  = 9;    // swallow count for channel index 0
    localparam int SPAN_LO = 8;    // legal channel indices, 20 MHz mode
    localparam int SPAN_HI = 13;   // legal channel indices, 5 MHz mode
    localparam int CH_W    = 4;    // channel index width
endpackage

// File: rtl/div34_core.sv
// Module div34_core
// Divide-by-3/4 core. It counts clock phases and flags the first and last
// phase of each core period. sel4 selects a four-phase period.
// Assumes sel4 holds steady for a whole period; the caller changes it only
// at period boundaries.
module div34_core (
    input  logic clk,
    input  logic rst_n,
    input  logic sel4,
    output logic first,
    output logic last
);
    logic [1:0] ph;

    assign first = (ph == 2'd0);
    assign last  = sel4 ? (ph == 2'd3) : (ph == 2'd2);

    // Phase counter: step forward each clock and wrap after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n)    ph <= 2'd0;
        else if (last) ph <= 2'd0;
        else           ph <= ph + 2'd1;
    end
endmodule

// File: rtl/dm_prescaler.sv
// Module dm_prescaler
// Dual-modulus N/N+1 prescaler made of a 3/4 core that runs CPF periods
// per frame. The four-phase periods sit at the end of the frame.
// The modulus input is sampled on the first clock of each frame. That
// clock always belongs to a three-phase period, so the swallow counter has
// one clock to settle after the frame-end edge and the two never race.
// Assumes N/3 - (N mod 3) >= 2; this holds for N = 10.
module dm_prescaler #(
    parameter int N = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mc,
    output logic frame_end,
    output logic mc_q
);
    localparam int CPF   = N / 3;               // core periods per frame
    localparam int FOURS = N - 3 * CPF;          // 4-periods at modulus N
    localparam int SW    = CPF - FOURS - 1;      // period swapped for N+1
    localparam int K_W   = (CPF > 1) ? $clog2(CPF) : 1;

    logic [K_W-1:0] k;
    logic           sel4, c_first, c_last, frame_start;

    assign sel4        = (k > K_W'(SW)) || ((k == K_W'(SW)) && mc_q);
    assign frame_start = c_first && (k == '0);
    assign frame_end   = c_last && (k == K_W'(CPF - 1));

    div34_core u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .sel4  (sel4),
        .first (c_first),
        .last  (c_last)
    );

    // Core period index within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)           k <= '0;
        else if (frame_end)   k <= '0;
        else if (c_last)      k <= k + K_W'(1);
    end

    // Sample the modulus control once per frame, on its first clock.
    always_ff @(posedge clk) begin
        if (!rst_n)           mc_q <= 1'b1;
        else if (frame_start) mc_q <= mc;
    end
endmodule

// File: rtl/swallow_ctrl.sv
// Module swallow_ctrl
// Program and swallow down-counters, both clocked by prescaler frame ends.
// The modulus request stays high while the swallow count is non-zero.
// When the program count runs out, one feedback pulse is emitted and both
// counters reload from the pending ratio.
// Assumes the pending S is smaller than the pending P.
module swallow_ctrl #(
    parameter int P_W   = 7,
    parameter int S_W   = 5,
    parameter int P_RST = 25,
    parameter int S_RST = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_end,
    input  logic [P_W-1:0] load_p,
    input  logic [S_W-1:0] load_s,
    output logic           fb_pulse,
    output logic           mc
);
    logic [P_W-1:0] left;
    logic [S_W-1:0] swl;
    logic           wrap;

    assign wrap = frame_end && (left == P_W'(1));
    assign mc   = (swl != '0);

    // Count frames down and reload both counters at the division boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= P_W'(P_RST);
            swl  <= S_W'(S_RST);
        end else if (wrap) begin
            left <= load_p;
            swl  <= load_s;
        end else if (frame_end) begin
            left <= left - P_W'(1);
            if (swl != '0) swl <= swl - S_W'(1);
        end
    end

    // Register the one-clock feedback pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) fb_pulse <= 1'b0;
        else        fb_pulse <= wrap;
    end
endmodule

// File: rtl/ratio_sel.sv
// Module ratio_sel
// Maps a channel index and mode to a pending (P, S) pair and rejects
// indices outside the mode's span. The pending pair is only read by the
// counters at a division boundary.
// Assumes spans fit in CH_W+1 bits.
module ratio_sel #(
    parameter int CH_W    = 4,
    parameter int P_W     = 7,
    parameter int S_W     = 5,
    parameter int P_LO    = 25,
    parameter int P_HI    = 114,
    parameter int S_BASE  = 9,
    parameter int SPAN_LO = 8,
    parameter int SPAN_HI = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            mode,
    input  logic [CH_W-1:0] chan,
    output logic [P_W-1:0]  pend_p,
    output logic [S_W-1:0]  pend_s,
    output logic            req_err
);
    localparam logic [CH_W:0] LIM_LO = (CH_W + 1)'(SPAN_LO);
    localparam logic [CH_W:0] LIM_HI = (CH_W + 1)'(SPAN_HI);

    logic           legal;
    logic [P_W-1:0] p_new;
    logic [S_W-1:0] s_new;

    // Decode the request into a ratio and check it against the span.
    always_comb begin
        legal = ({1'b0, chan} < (mode ? LIM_HI : LIM_LO));
        p_new = mode ? P_W'(P_HI) : P_W'(P_LO);
        s_new = S_W'(S_BASE) + S_W'(chan);
    end

    // Keep the pending ratio; a refused request leaves it as it was.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_p <= P_W'(P_LO);
            pend_s <= S_W'(S_BASE);
        end else if (req && legal) begin
            pend_p <= p_new;
            pend_s <= s_new;
        end
    end

    // Report whether the most recent request was refused.
    always_ff @(posedge clk) begin
        if (!rst_n)   req_err <= 1'b0;
        else if (req) req_err <= !legal;
    end
endmodule

// File: rtl/pulse_swallow_div.sv
// Module pulse_swallow_div
// Top of the feedback divider. The division ratio is PRE_N*P + S, chosen
// from a channel index under one of two reference modes.
// Assumes clk is the halved oscillator clock.
module pulse_swallow_div #(
    parameter int PRE_N   = div_pkg::PRE_N,
    parameter int P_LO    = div_pkg::P_LO,
    parameter int P_HI    = div_pkg::P_HI,
    parameter int S_BASE  = div_pkg::S_BASE,
    parameter int SPAN_LO = div_pkg::SPAN_LO,
    parameter int SPAN_HI = div_pkg::SPAN_HI,
    parameter int CH_W    = div_pkg::CH_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            mode,
    input  logic [CH_W-1:0] chan,
    output logic            fb_pulse,
    output logic            mod_ctl,
    output logic            req_err
);
    localparam int P_W = $clog2(P_HI + 1);
    localparam int S_W = $clog2(S_BASE + SPAN_HI);

    logic [P_W-1:0] pend_p;
    logic [S_W-1:0] pend_s;
    logic           frame_end, mc;

    ratio_sel #(
        .CH_W(CH_W), .P_W(P_W), .S_W(S_W), .P_LO(P_LO), .P_HI(P_HI),
        .S_BASE(S_BASE), .SPAN_LO(SPAN_LO), .SPAN_HI(SPAN_HI)
    ) u_sel (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .chan(chan),
        .pend_p(pend_p), .pend_s(pend_s), .req_err(req_err)
    );

    dm_prescaler #(.N(PRE_N)) u_pre (
        .clk(clk), .rst_n(rst_n), .mc(mc),
        .frame_end(frame_end), .mc_q(mod_ctl)
    );

    swallow_ctrl #(
        .P_W(P_W), .S_W(S_W), .P_RST(P_LO), .S_RST(S_BASE)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
        .load_p(pend_p), .load_s(pend_s),
        .fb_pulse(fb_pulse), .mc(mc)
    );
endmodule

// File: rtl/div_chk.sv
// Module div_chk
// Checker bound to pulse_swallow_div. It watches the request flag, the
// pulse shape, the modulus timing and the longest possible pulse gap.
module div_chk #(
    parameter int CH_W    = div_pkg::CH_W,
    parameter int SPAN_LO = div_pkg::SPAN_LO,
    parameter int SPAN_HI = div_pkg::SPAN_HI,
    parameter int GAP_MAX = div_pkg::PRE_N * div_pkg::P_HI + div_pkg::S_BASE
                            + div_pkg::SPAN_HI + 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req,
    input logic            mode,
    input logic [CH_W-1:0] chan,
    input logic            fb_pulse,
    input logic            mod_ctl,
    input logic            req_err
);
    localparam logic [CH_W:0] LIM_LO = (CH_W + 1)'(SPAN_LO);
    localparam logic [CH_W:0] LIM_HI = (CH_W + 1)'(SPAN_HI);

    logic        bad_req;
    logic [15:0] gap;

    assign bad_req = req && ({1'b0, chan} >= (mode ? LIM_HI : LIM_LO));

    // Clocks since the last feedback pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        gap <= '0;
        else if (fb_pulse) gap <= '0;
        else               gap <= gap + 16'd1;
    end

    // R4
    bad_req_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |=> req_err);

    // R5
    good_req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !bad_req) |=> !req_err);

    // R5
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(req_err));

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    // R8
    mod_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> mod_ctl);

    // R8
    mod_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_ctl) |-> $past(fb_pulse));

    // R3
    pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap <= 16'(GAP_MAX));
endmodule

bind pulse_swallow_div div_chk u_div_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .chan(chan),
    .fb_pulse(fb_pulse), .mod_ctl(mod_ctl), .req_err(req_err)
);

// File: tb/test_pulse_swallow_div.sv
`timescale 1ns/1ps
// Bench for pulse_swallow_div: a table of channel requests, then directed
// reset, back-to-back and flag-hold cases.
module test_pulse_swallow_div;
    localparam int NVEC = 26;
    // {mode, chan}
    localparam logic [4:0] VEC [NVEC] = '{
        5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07,
        5'h08, 5'h0F,
        5'h10, 5'h11, 5'h12, 5'h13, 5'h14, 5'h15, 5'h16, 5'h17,
        5'h18, 5'h19, 5'h1A, 5'h1B, 5'h1C,
        5'h1D, 5'h1F, 5'h03
    };

    logic       clk = 1'b0, rst_n = 1'b0, req = 1'b0, mode = 1'b0;
    logic [3:0] chan = 4'd0;
    logic       fb_pulse, mod_ctl, req_err;

    int checks = 0, errors = 0, cyc = 0;
    int prev_ratio = 259, prev_s = 9;

    always #2.5 clk = ~clk;

    pulse_swallow_div i_pulse_swallow_div (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .chan(chan),
        .fb_pulse(fb_pulse), .mod_ctl(mod_ctl), .req_err(req_err)
    );

    // Count one check and report it if it failed.
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Count clocks and mod_ctl-high clocks up to and including the next pulse.
    task automatic wait_pulse(output int n, output int mh);
        n = 0; mh = 0;
        do begin
            @(negedge clk);
            n++;
            if (mod_ctl) mh++;
        end while (!fb_pulse && n < 3000);
    endtask

    // Apply one request on a pulse edge and check the old and new intervals.
    task automatic step(input bit m, input int c);
        bit legal = (c < (m ? 13 : 8));
        int s_exp = legal ? 9 + c : prev_s;
        int r_exp = legal ? 10 * (m ? 114 : 25) + 9 + c : prev_ratio;
        int n, mh;
        req = 1'b1; mode = m; chan = c[3:0];
        @(negedge clk);
        req = 1'b0;
        chk(req_err == !legal, legal ? "R5 flag" : "R4 flag", req_err, !legal);
        chk(fb_pulse == 1'b0, "R7 width", fb_pulse, 0);
        n = 1;
        while (!fb_pulse && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(n == prev_ratio, "R6 old interval", n, prev_ratio);
        wait_pulse(n, mh);
        chk(n == r_exp, !legal ? "R4 kept" : (m ? "R3 ratio" : "R2 ratio"), n, r_exp);
        chk(mh == 11 * s_exp, "R8 swallow", mh, 11 * s_exp);
        prev_ratio = r_exp; prev_s = s_exp;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, mh;
        repeat (3) @(negedge clk);
        chk(fb_pulse == 1'b0, "R1 pulse", fb_pulse, 0);
        chk(req_err == 1'b0, "R1 err", req_err, 0);
        chk(mod_ctl == 1'b1, "R1 mod", mod_ctl, 1);
        rst_n = 1'b1;
        wait_pulse(n, mh);
        wait_pulse(n, mh);
        chk(n == 259, "R1 ratio", n, 259);
        chk(mh == 99, "R8 swallow", mh, 99);

        for (int i = 0; i < NVEC; i++)
            step(VEC[i][4], int'(VEC[i][3:0]));

        // R5: a refused request leaves the flag set until the next request.
        step(1'b0, 15);
        repeat (5) @(negedge clk);
        chk(req_err == 1'b1, "R5 hold", req_err, 1);
        wait_pulse(n, mh);

        // R6: two requests in one cycle; the later one is applied.
        req = 1'b1; mode = 1'b1; chan = 4'd2;
        @(negedge clk);
        mode = 1'b0; chan = 4'd5;
        @(negedge clk);
        req = 1'b0;
        wait_pulse(n, mh);
        wait_pulse(n, mh);
        chk(n == 264, "R6 last wins", n, 264);
        prev_ratio = 264; prev_s = 14;

        // R1: reset in mid-run restores the default ratio.
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(fb_pulse == 1'b0, "R1 pulse", fb_pulse, 0);
        chk(mod_ctl == 1'b1, "R1 mod", mod_ctl, 1);
        chk(req_err == 1'b0, "R1 err", req_err, 0);
        rst_n = 1'b1;
        wait_pulse(n, mh);
        wait_pulse(n, mh);
        chk(n == 259, "R1 ratio", n, 259);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule